// File: doc/BRIEF.md
# Register-Mapped SPI Master with FIFOs

This block is a serial peripheral interface master that software drives through a small 32-bit register window. Software writes words into a transmit FIFO. The shift engine takes each word in turn, serialises it on the serial clock and MOSI pins, and captures MISO into a receive FIFO. Software then drains the received words from the data register. A transfer-hold bit in the control register keeps the engine idle, so that software can preload several words and release them as one back-to-back burst.

Clock polarity and phase are selectable, and so is the bit order. An internal loopback path returns MOSI straight to the receiver. Slave selects are one-hot and active low, and come from a software register. A pin-enable bit releases every output enable, which tri-states the pins. Writing a key value to a dedicated register returns the whole block to its reset state. The word width, the number of slave selects, the FIFO depth and the serial clock divider are elaboration parameters.

The engine is a three-state machine with the states `SH_IDLE`, `SH_LEAD` and `SH_TRAIL`. Its transitions are:

- **launch**: `SH_IDLE`→`SH_LEAD`. Taken when the pins are enabled, master mode is set, the hold bit is clear, the TX FIFO holds a word and the RX FIFO has room. The word is popped on this transition.
- **lead_edge**: `SH_LEAD`→`SH_TRAIL`. Taken after half a serial clock period.
- **next_bit**: `SH_TRAIL`→`SH_LEAD`. Taken after half a period while bits remain.
- **word_done**: `SH_TRAIL`→`SH_IDLE`. Taken after the last trailing edge. The received word is pushed to the RX FIFO on this transition.

Top module: `spi_master_mm`

## Requirements
- R1: After a hardware reset, the block returns to its reset state: control reads 0x100 (only the hold bit set), slave select reads all ones, both FIFOs are empty and status reads 0x005. Writing 0xA to offset 0x40 restores this same reset state. Writing any other value to 0x40 changes nothing.
- R2: The control register is at offset 0x60, with these bits: 0 loopback, 1 pin enable, 2 master, 3 CPOL, 4 CPHA, 5 TX flush, 6 RX flush, 7 manual select, 8 transfer hold, 9 LSB first. Writing 1 to bit 5 empties the TX FIFO, and writing 1 to bit 6 empties the RX FIFO. Both flush bits always read back 0.
- R3: While bit 8 is 1, no serial clock edge occurs, even when the TX FIFO holds words. Once bit 8 is 0, words are shifted one after another until the TX FIFO is empty.
- R4: Each word produces exactly 2×WORD_W serial clock edges, and the clock rests at the CPOL level between words. With CPHA=0 both sides sample on the leading edge. With CPHA=1 both sides sample on the trailing edge. MOSI changes only on the other edge.
- R5: Bits are sent and received MSB first by default. With bit 9 set, bits are sent and received LSB first.
- R6: With bit 0 set, the receiver captures the block's own MOSI and the MISO pin has no effect.
- R7: The slave-select register at 0x70 is one-hot and active low, and resets to all ones. With bit 7 set, the pins follow the register at all times. With bit 7 clear, the pins follow the register only during a word and are all ones otherwise.
- R8: With bit 1 at 0, the output enables for the serial clock, MOSI and the selects are all 0, and no word is shifted.
- R9: The status register is at 0x64, with these bits: 0 RX empty, 1 RX full, 2 TX empty, 3 TX full, 7 slave-mode error. Bit 7 is set by a control write with bit 2 at 0 and cleared by a control write with bit 2 at 1. No word is shifted while bit 2 is 0.
- R10: A write to 0x68 pushes the low WORD_W bits, and the write is dropped when the TX FIFO is full. A read of 0x6C pops one word, and returns 0 without popping when the RX FIFO is empty. Offsets 0x74 and 0x78 read the TX and RX word counts.
- R11: A serial clock edge occurs every CLK_DIV/2 system clocks within a word. The first edge and the last edge of a word are (2×WORD_W−1)×CLK_DIV/2 cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; a read of 0x6C pops a word |
| reg_addr | input | 8 | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid in the same cycle as the address |
| sclk_o | output | 1 | Serial clock |
| sclk_oe | output | 1 | Serial clock output enable |
| mosi_o | output | 1 | Serial data out |
| mosi_oe | output | 1 | Serial data output enable |
| miso_i | input | 1 | Serial data in |
| ss_n_o | output | NUM_SS | Active-low slave selects |
| ss_oe | output | 1 | Slave select output enable |

## Verification
The assertions assume the following about the inputs:

- The register bus issues at most one access per cycle and never asserts a read and a write together.
- CPOL, CPHA, loopback and bit order are not changed while a word is on the wire.

The stimulus keeps within these assumptions. It performs one register operation per cycle through single-cycle tasks, and it changes the mode bits only after a wait long enough for the FIFO contents to drain completely. The bench's slave model also relies on MISO being allowed to change as soon as it has sampled an edge. The model updates MISO a few nanoseconds after each system clock edge.

// File: rtl/spi_master_mm_pkg.sv
package spi_master_mm_pkg;

    typedef enum logic [1:0] {
        SH_IDLE  = 2'd0,
        SH_LEAD  = 2'd1,
        SH_TRAIL = 2'd2
    } sh_state_e;

    // Field order is software visible: bit 9 down to bit 0.
    typedef struct packed {
        logic lsb_first;
        logic xfer_hold;
        logic manual_sel;
        logic rx_flush;
        logic tx_flush;
        logic cpha;
        logic cpol;
        logic master;
        logic pin_en;
        logic loopback;
    } ctrl_t;

    localparam logic [7:0] OFS_SRST  = 8'h40;
    localparam logic [7:0] OFS_CTRL  = 8'h60;
    localparam logic [7:0] OFS_STAT  = 8'h64;
    localparam logic [7:0] OFS_TXD   = 8'h68;
    localparam logic [7:0] OFS_RXD   = 8'h6C;
    localparam logic [7:0] OFS_SSEL  = 8'h70;
    localparam logic [7:0] OFS_TXOCC = 8'h74;
    localparam logic [7:0] OFS_RXOCC = 8'h78;

    localparam logic [31:0] SRST_KEY = 32'h0000_000A;
    localparam logic [9:0]  CTRL_RST = 10'h100;

endpackage

// File: rtl/spi_mm_fifo.sv
module spi_mm_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 4,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          push,
    input  logic [W-1:0]  din,
    input  logic          pop,
    output logic [W-1:0]  dout,
    output logic [CW-1:0] count,
    output logic          empty,
    output logic          full
);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] cnt_q;
    logic          do_push, do_pop;

    assign empty   = (cnt_q == '0);
    assign full    = (cnt_q == CW'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rd_ptr];
    assign count   = cnt_q;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt_q  <= '0;
        end else if (clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt_q  <= '0;
        end else begin
            if (do_push) wr_ptr <= bump(wr_ptr);
            if (do_pop)  rd_ptr <= bump(rd_ptr);
            unique case ({do_push, do_pop})
                2'b10:   cnt_q <= cnt_q + CW'(1);
                2'b01:   cnt_q <= cnt_q - CW'(1);
                default: cnt_q <= cnt_q;
            endcase
        end
    end

endmodule

// File: rtl/spi_mm_shifter.sv
module spi_mm_shifter
    import spi_master_mm_pkg::*;
#(
    parameter int W       = 8,
    parameter int CLK_DIV = 4,
    localparam int HALF   = CLK_DIV / 2,
    localparam int DW     = (HALF > 1) ? $clog2(HALF) : 1,
    localparam int BW     = $clog2(W)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         go_ok,
    input  logic         tx_valid,
    input  logic [W-1:0] tx_word,
    input  logic         rx_ready,
    input  logic         cpol,
    input  logic         cpha,
    input  logic         lsb_first,
    input  logic         loopback,
    input  logic         miso,
    output logic         tx_pop,
    output logic         rx_push,
    output logic [W-1:0] rx_word,
    output logic         sclk,
    output logic         mosi,
    output logic         busy
);

    sh_state_e     state_q, state_d;
    logic [DW-1:0] div_q;
    logic [BW-1:0] bit_q;
    logic [W-1:0]  sh_q, rx_q;
    logic          mosi_q;

    logic          go, half_done, last_bit, din;
    logic [W-1:0]  load_word, rx_shift;

    function automatic logic [W-1:0] orient(input logic [W-1:0] v, input logic rev);
        logic [W-1:0] r;
        for (int i = 0; i < W; i++) r[i] = v[W-1-i];
        return rev ? r : v;
    endfunction

    assign go        = go_ok && tx_valid && rx_ready;
    assign half_done = (div_q == DW'(HALF - 1));
    assign last_bit  = (bit_q == BW'(W - 1));
    assign din       = loopback ? mosi_q : miso;
    assign rx_shift  = {rx_q[W-2:0], din};
    assign load_word = orient(tx_word, lsb_first);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   state_q <= SH_IDLE;
        else if (clr) state_q <= SH_IDLE;
        else          state_q <= state_d;
    end

    // transitions: launch, lead_edge, next_bit, word_done
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SH_IDLE:  if (go) state_d = SH_LEAD;
            SH_LEAD:  if (half_done) state_d = SH_TRAIL;
            SH_TRAIL: if (half_done) state_d = last_bit ? SH_IDLE : SH_LEAD;
            default:  state_d = SH_IDLE;
        endcase
    end

    // datapath: divider, bit counter, shift registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q  <= '0;
            bit_q  <= '0;
            sh_q   <= '0;
            rx_q   <= '0;
            mosi_q <= 1'b0;
        end else if (clr) begin
            div_q  <= '0;
            bit_q  <= '0;
            sh_q   <= '0;
            rx_q   <= '0;
            mosi_q <= 1'b0;
        end else begin
            unique case (state_q)
                SH_IDLE: begin
                    if (go) begin
                        div_q <= '0;
                        bit_q <= '0;
                        rx_q  <= '0;
                        if (cpha) begin
                            sh_q   <= load_word;
                            mosi_q <= 1'b0;
                        end else begin
                            sh_q   <= {load_word[W-2:0], 1'b0};
                            mosi_q <= load_word[W-1];
                        end
                    end
                end
                SH_LEAD: begin
                    if (half_done) begin
                        div_q <= '0;
                        if (cpha) begin
                            mosi_q <= sh_q[W-1];
                            sh_q   <= {sh_q[W-2:0], 1'b0};
                        end else begin
                            rx_q <= rx_shift;
                        end
                    end else begin
                        div_q <= div_q + DW'(1);
                    end
                end
                SH_TRAIL: begin
                    if (half_done) begin
                        div_q <= '0;
                        if (cpha) begin
                            rx_q <= rx_shift;
                        end else if (!last_bit) begin
                            mosi_q <= sh_q[W-1];
                            sh_q   <= {sh_q[W-2:0], 1'b0};
                        end
                        if (!last_bit) bit_q <= bit_q + BW'(1);
                    end else begin
                        div_q <= div_q + DW'(1);
                    end
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        sclk    = (state_q == SH_TRAIL) ? ~cpol : cpol;
        mosi    = mosi_q;
        busy    = (state_q != SH_IDLE);
        tx_pop  = (state_q == SH_IDLE) && go;
        rx_push = (state_q == SH_TRAIL) && half_done && last_bit;
        rx_word = orient(cpha ? rx_shift : rx_q, lsb_first);
    end

endmodule

// File: rtl/spi_master_mm.sv
module spi_master_mm
    import spi_master_mm_pkg::*;
#(
    parameter int   WORD_W     = 8,
    parameter int   NUM_SS     = 4,
    parameter int   FIFO_DEPTH = 4,
    parameter int   CLK_DIV    = 4,
    parameter logic LSB_OK     = 1'b1,
    localparam int  CW         = $clog2(FIFO_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [7:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              sclk_o,
    output logic              sclk_oe,
    output logic              mosi_o,
    output logic              mosi_oe,
    input  logic              miso_i,
    output logic [NUM_SS-1:0] ss_n_o,
    output logic              ss_oe
);

    ctrl_t             ctrl_q;
    logic [NUM_SS-1:0] ss_q;
    logic              err_slave_q, err_msb_q;

    logic soft_hit, ctrl_wr, ss_wr, tx_flush, rx_flush;
    logic tx_push, rx_pop, go_ok, eng_busy;
    logic tx_pop, rx_push, tx_empty, tx_full, rx_empty, rx_full;
    logic [WORD_W-1:0] tx_head, rx_head, rx_word;
    logic [CW-1:0]     tx_cnt, rx_cnt;
    logic              eng_sclk, eng_mosi;

    assign soft_hit = reg_wr && (reg_addr == OFS_SRST) && (reg_wdata == SRST_KEY);
    assign ctrl_wr  = reg_wr && (reg_addr == OFS_CTRL);
    assign ss_wr    = reg_wr && (reg_addr == OFS_SSEL);
    assign tx_flush = ctrl_wr && reg_wdata[5];
    assign rx_flush = ctrl_wr && reg_wdata[6];
    assign tx_push  = reg_wr && (reg_addr == OFS_TXD);
    assign rx_pop   = reg_rd && (reg_addr == OFS_RXD);
    assign go_ok    = ctrl_q.pin_en && ctrl_q.master && !ctrl_q.xfer_hold;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q      <= ctrl_t'(CTRL_RST);
            ss_q        <= '1;
            err_slave_q <= 1'b0;
            err_msb_q   <= 1'b0;
        end else if (soft_hit) begin
            ctrl_q      <= ctrl_t'(CTRL_RST);
            ss_q        <= '1;
            err_slave_q <= 1'b0;
            err_msb_q   <= 1'b0;
        end else begin
            if (ctrl_wr) begin
                ctrl_q          <= ctrl_t'(reg_wdata[9:0]);
                ctrl_q.tx_flush <= 1'b0;
                ctrl_q.rx_flush <= 1'b0;
                err_slave_q     <= !reg_wdata[2];
                err_msb_q       <= reg_wdata[9] && !LSB_OK;
            end
            if (ss_wr) ss_q <= reg_wdata[NUM_SS-1:0];
        end
    end

    spi_mm_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) tx_fifo_i (
        .clk(clk), .rst_n(rst_n), .clr(soft_hit || tx_flush),
        .push(tx_push), .din(reg_wdata[WORD_W-1:0]), .pop(tx_pop),
        .dout(tx_head), .count(tx_cnt), .empty(tx_empty), .full(tx_full)
    );

    spi_mm_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) rx_fifo_i (
        .clk(clk), .rst_n(rst_n), .clr(soft_hit || rx_flush),
        .push(rx_push), .din(rx_word), .pop(rx_pop),
        .dout(rx_head), .count(rx_cnt), .empty(rx_empty), .full(rx_full)
    );

    spi_mm_shifter #(.W(WORD_W), .CLK_DIV(CLK_DIV)) shifter_i (
        .clk(clk), .rst_n(rst_n), .clr(soft_hit),
        .go_ok(go_ok), .tx_valid(!tx_empty), .tx_word(tx_head),
        .rx_ready(!rx_full), .cpol(ctrl_q.cpol), .cpha(ctrl_q.cpha),
        .lsb_first(ctrl_q.lsb_first && LSB_OK), .loopback(ctrl_q.loopback),
        .miso(miso_i), .tx_pop(tx_pop), .rx_push(rx_push), .rx_word(rx_word),
        .sclk(eng_sclk), .mosi(eng_mosi), .busy(eng_busy)
    );

    always_comb begin
        sclk_o  = eng_sclk;
        mosi_o  = eng_mosi;
        sclk_oe = ctrl_q.pin_en;
        mosi_oe = ctrl_q.pin_en;
        ss_oe   = ctrl_q.pin_en;
        ss_n_o  = (ctrl_q.manual_sel || eng_busy) ? ss_q : '1;
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            OFS_CTRL:  reg_rdata = {22'd0, ctrl_q};
            OFS_STAT:  reg_rdata = {23'd0, err_msb_q, err_slave_q, 3'd0,
                                    tx_full, tx_empty, rx_full, rx_empty};
            OFS_RXD:   reg_rdata = rx_empty ? '0 : 32'(rx_head);
            OFS_SSEL:  reg_rdata = 32'(ss_q);
            OFS_TXOCC: reg_rdata = 32'(tx_cnt);
            OFS_RXOCC: reg_rdata = 32'(rx_cnt);
            default:   reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/spi_master_mm_chk.sv
module spi_master_mm_chk #(
    parameter int  FIFO_DEPTH = 4,
    parameter int  NUM_SS     = 4,
    localparam int CW         = $clog2(FIFO_DEPTH + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic [9:0]        ctrl_bits,
    input logic              soft_hit,
    input logic              tx_flush,
    input logic [NUM_SS-1:0] ss_q,
    input logic [NUM_SS-1:0] ss_n_o,
    input logic              eng_busy,
    input logic              rx_push,
    input logic              rx_full,
    input logic [CW-1:0]     tx_cnt
);

    // R3
    hold_keeps_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_bits[8] && !eng_busy) |=> !eng_busy);

    // R7
    manual_sel_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_bits[7] |-> (ss_n_o == ss_q));

    // R7
    auto_sel_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_bits[7] && !eng_busy) |-> (ss_n_o == '1));

    // R10
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_cnt <= CW'(FIFO_DEPTH));

    // R10
    rx_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_push |-> !rx_full);

    // R2
    tx_flush_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_flush |=> (tx_cnt == '0));

    // R1
    soft_reset_ctrl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        soft_hit |=> (ctrl_bits == 10'h100 && ss_q == '1 && !eng_busy));

endmodule

bind spi_master_mm spi_master_mm_chk #(.FIFO_DEPTH(FIFO_DEPTH), .NUM_SS(NUM_SS)) chk_i (
    .clk(clk), .rst_n(rst_n), .ctrl_bits(ctrl_q), .soft_hit(soft_hit),
    .tx_flush(tx_flush), .ss_q(ss_q), .ss_n_o(ss_n_o), .eng_busy(eng_busy),
    .rx_push(rx_push), .rx_full(rx_full), .tx_cnt(tx_cnt)
);

// File: tb/spi_master_mm_tb_top.sv
module spi_master_mm_tb_top;

    localparam int W = 8, NSS = 4, DEPTH = 4, DIV = 4, HALF = DIV / 2;
    localparam int WORD_CYC = 2 * HALF * W + 1;

    logic clk = 1'b0, rst_n = 1'b0;
    logic reg_wr = 1'b0, reg_rd = 1'b0;
    logic [7:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0, reg_rdata;
    logic sclk_o, sclk_oe, mosi_o, mosi_oe, ss_oe;
    logic miso_i;
    logic [NSS-1:0] ss_n_o;

    always #4 clk = ~clk;

    spi_master_mm #(.WORD_W(W), .NUM_SS(NSS), .FIFO_DEPTH(DEPTH), .CLK_DIV(DIV)) dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .sclk_o(sclk_o), .sclk_oe(sclk_oe), .mosi_o(mosi_o), .mosi_oe(mosi_oe),
        .miso_i(miso_i), .ss_n_o(ss_n_o), .ss_oe(ss_oe)
    );

    int n_chk = 0, n_fail = 0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // reference model of software-visible state
    logic [9:0]     mdl_ctrl = 10'h100;
    logic [NSS-1:0] mdl_ss = '1;
    logic [W-1:0]   slv_q[$];
    logic [W-1:0]   got_q[$];
    logic [W-1:0]   slv_rx = '0;
    logic           slv_bit = 1'b0;
    logic           prev_sclk = 1'b0;
    int edge_n = 0, smp = 0, edges_total = 0, first_cyc = 0, cyc = 0, auto_seen = 0;

    assign miso_i = slv_bit;

    function automatic logic [W-1:0] rev(input logic [W-1:0] v);
        logic [W-1:0] r;
        for (int i = 0; i < W; i++) r[i] = v[W-1-i];
        return r;
    endfunction

    // per-clock comparison and behavioural slave
    always @(posedge clk) begin
        #3;
        if (rst_n) begin
            chk(sclk_oe === mdl_ctrl[1] && mosi_oe === mdl_ctrl[1] && ss_oe === mdl_ctrl[1],
                "R8 output enables", {29'd0, sclk_oe, mosi_oe, ss_oe}, {29'd0, {3{mdl_ctrl[1]}}});
            if (mdl_ctrl[7])
                chk(ss_n_o === mdl_ss, "R7 manual select", 32'(ss_n_o), 32'(mdl_ss));
            if (sclk_o !== prev_sclk && !(edge_n == 0 && sclk_o == mdl_ctrl[3])) begin
                automatic logic leading = (prev_sclk == mdl_ctrl[3]);
                if (edge_n == 0) first_cyc = cyc;
                if (leading && !mdl_ctrl[7]) begin
                    chk(ss_n_o === mdl_ss, "R7 auto select in word", 32'(ss_n_o), 32'(mdl_ss));
                    auto_seen++;
                end
                if ((!mdl_ctrl[4] && leading) || (mdl_ctrl[4] && !leading)) begin
                    slv_rx = {slv_rx[W-2:0], mosi_o};
                    smp++;
                end
                edge_n++;
                edges_total++;
                if (edge_n == 2 * W) begin
                    got_q.push_back(slv_rx);
                    chk(cyc - first_cyc == (2 * W - 1) * HALF, "R11 word duration",
                        32'(cyc - first_cyc), 32'((2 * W - 1) * HALF));
                    if (slv_q.size() > 0) void'(slv_q.pop_front());
                    edge_n = 0;
                    smp = 0;
                end
            end
            prev_sclk = sclk_o;
            cyc++;
            begin
                automatic logic [W-1:0] cur = (slv_q.size() > 0) ? slv_q[0] : '0;
                slv_bit = (smp < W) ? cur[W-1-smp] : 1'b0;
            end
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk);
        #1;
        reg_wr = 1'b0;
        if (a == 8'h60) mdl_ctrl = d[9:0] & 10'h39F;
        if (a == 8'h70) mdl_ss = d[NSS-1:0];
        if (a == 8'h40 && d == 32'hA) begin
            mdl_ctrl = 10'h100;
            mdl_ss = '1;
        end
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        #1 v = reg_rdata;
        @(posedge clk);
        #1 reg_rd = 1'b0;
    endtask

    task automatic expect_rd(input logic [7:0] a, input logic [31:0] e, input string req);
        logic [31:0] v;
        rd(a, v);
        chk(v === e, req, v, e);
    endtask

    task automatic wait_words(input int n);
        repeat (n * WORD_CYC + 12) @(posedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int e0;
        repeat (5) @(posedge clk);
        #1 rst_n = 1'b1;
        repeat (2) @(posedge clk);

        // R1 / R9 / R10 / R8 reset state
        expect_rd(8'h60, 32'h100, "R1 ctrl reset");
        expect_rd(8'h64, 32'h005, "R1 R9 status reset");
        expect_rd(8'h70, 32'hF, "R7 select reset");
        expect_rd(8'h74, 32'h0, "R10 tx count reset");
        expect_rd(8'h78, 32'h0, "R10 rx count reset");
        chk(sclk_oe === 1'b0, "R8 pins off at reset", 32'(sclk_oe), 32'h0);

        // R3 hold while preloading
        wr(8'h60, 32'h186);
        wr(8'h70, 32'hE);
        slv_q.push_back(8'h3C); slv_q.push_back(8'hA5); slv_q.push_back(8'h0F);
        wr(8'h68, 32'h96); wr(8'h68, 32'h5A); wr(8'h68, 32'hC3);
        repeat (40) @(posedge clk);
        chk(edges_total == 0, "R3 no edges while held", 32'(edges_total), 32'h0);
        expect_rd(8'h74, 32'h3, "R10 tx count 3");
        wr(8'h60, 32'h086);
        wait_words(3);
        chk(edges_total == 6 * W, "R4 edge count burst", 32'(edges_total), 32'(6 * W));
        chk(got_q.size() == 3, "R3 back-to-back words", 32'(got_q.size()), 32'h3);
        if (got_q.size() == 3) begin
            chk(got_q[0] == 8'h96, "R5 msb-first word0", 32'(got_q[0]), 32'h96);
            chk(got_q[1] == 8'h5A, "R4 word1", 32'(got_q[1]), 32'h5A);
            chk(got_q[2] == 8'hC3, "R4 word2", 32'(got_q[2]), 32'hC3);
        end
        expect_rd(8'h78, 32'h3, "R10 rx count 3");
        expect_rd(8'h6C, 32'h3C, "R4 rx word0");
        expect_rd(8'h6C, 32'hA5, "R4 rx word1");
        expect_rd(8'h6C, 32'h0F, "R4 rx word2");
        got_q.delete();

        // R4 R5 CPOL=1 CPHA=1 LSB first
        wr(8'h60, 32'h29E);
        slv_q.push_back(8'h4E);
        wr(8'h68, 32'hB1);
        wait_words(1);
        chk(got_q.size() == 1 && got_q[0] == rev(8'hB1), "R5 lsb-first tx",
            (got_q.size() > 0) ? 32'(got_q[0]) : 32'hDEAD, 32'(rev(8'hB1)));
        expect_rd(8'h6C, 32'(rev(8'h4E)), "R5 lsb-first rx");
        chk(sclk_o === 1'b1, "R4 idle at CPOL=1", 32'(sclk_o), 32'h1);
        got_q.delete();

        // R4 CPOL=1 CPHA=0
        wr(8'h60, 32'h08E);
        slv_q.push_back(8'hE1);
        wr(8'h68, 32'h3C);
        wait_words(1);
        chk(got_q.size() == 1 && got_q[0] == 8'h3C, "R4 cpha0 tx",
            (got_q.size() > 0) ? 32'(got_q[0]) : 32'hDEAD, 32'h3C);
        expect_rd(8'h6C, 32'hE1, "R4 cpha0 rx");
        got_q.delete();

        // R6 loopback, MISO held at ones
        wr(8'h60, 32'h087);
        slv_q.push_back(8'hFF);
        wr(8'h68, 32'h5A);
        wait_words(1);
        expect_rd(8'h6C, 32'h5A, "R6 loopback rx");
        chk(got_q.size() == 1 && got_q[0] == 8'h5A, "R6 mosi still driven",
            (got_q.size() > 0) ? 32'(got_q[0]) : 32'hDEAD, 32'h5A);
        got_q.delete();
        slv_q.delete();

        // R7 automatic select
        wr(8'h60, 32'h006);
        wr(8'h70, 32'hB);
        repeat (2) @(posedge clk);
        chk(ss_n_o === 4'hF, "R7 auto idle high", 32'(ss_n_o), 32'hF);
        auto_seen = 0;
        wr(8'h68, 32'h77);
        wait_words(1);
        chk(auto_seen == W, "R7 auto select during word", 32'(auto_seen), 32'(W));
        chk(ss_n_o === 4'hF, "R7 auto released", 32'(ss_n_o), 32'hF);
        expect_rd(8'h6C, 32'h0, "R10 rx word");
        got_q.delete();

        // R8 pins disabled, then R2 TX flush
        wr(8'h60, 32'h004);
        e0 = edges_total;
        wr(8'h68, 32'h11);
        repeat (50) @(posedge clk);
        chk(edges_total == e0, "R8 no shift when disabled", 32'(edges_total), 32'(e0));
        expect_rd(8'h74, 32'h1, "R8 word kept");
        wr(8'h60, 32'h024);
        expect_rd(8'h74, 32'h0, "R2 tx flush");
        expect_rd(8'h60, 32'h004, "R2 flush bit reads 0");

        // R9 slave-mode error
        wr(8'h60, 32'h002);
        expect_rd(8'h64, 32'h085, "R9 slave error set");
        e0 = edges_total;
        wr(8'h68, 32'h22);
        repeat (50) @(posedge clk);
        chk(edges_total == e0, "R9 no shift without master", 32'(edges_total), 32'(e0));
        wr(8'h60, 32'h106);
        expect_rd(8'h64, 32'h001, "R9 slave error cleared");
        wr(8'h60, 32'h126);
        expect_rd(8'h60, 32'h106, "R2 ctrl after flush");
        expect_rd(8'h74, 32'h0, "R2 tx emptied");

        // R10 full FIFO, empty read
        for (int i = 1; i <= DEPTH + 1; i++) wr(8'h68, 32'(i));
        expect_rd(8'h74, 32'(DEPTH), "R10 tx count saturates");
        expect_rd(8'h64, 32'h009, "R9 tx full status");
        expect_rd(8'h6C, 32'h0, "R10 empty read");
        expect_rd(8'h78, 32'h0, "R10 empty read no pop");
        wr(8'h60, 32'h006);
        wait_words(DEPTH);
        chk(got_q.size() == DEPTH, "R10 dropped push", 32'(got_q.size()), 32'(DEPTH));
        if (got_q.size() == DEPTH)
            chk(got_q[DEPTH-1] == W'(DEPTH), "R10 last kept word", 32'(got_q[DEPTH-1]), 32'(DEPTH));
        expect_rd(8'h64, 32'h006, "R9 rx full status");
        expect_rd(8'h78, 32'(DEPTH), "R10 rx count");
        wr(8'h60, 32'h046);
        expect_rd(8'h78, 32'h0, "R2 rx flush");
        expect_rd(8'h60, 32'h006, "R2 rx flush bit reads 0");

        // R1 soft reset key
        wr(8'h40, 32'h5);
        expect_rd(8'h60, 32'h006, "R1 wrong key ignored");
        wr(8'h40, 32'hA);
        expect_rd(8'h60, 32'h100, "R1 soft reset ctrl");
        expect_rd(8'h70, 32'hF, "R1 soft reset select");
        expect_rd(8'h64, 32'h005, "R1 soft reset status");

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule